// File: doc/BRIEF.md
# Banked-Register Interrupt Distributor

This block gathers a parameterised number of level-sensitive interrupt lines (a multiple of 32, at most 1024) and selects one of them for a single CPU interface. Each line has its own enable, pending and active state, an 8-bit priority and an 8-bit processor-target byte. Software reaches all of this through a word-wide register bus that spans a 4 KiB window. Enable, pending and active state are changed through paired banks. One bank of each pair sets the bits written as 1, the other clears them, and bits written as 0 are left alone.

The block searches the registered state for the best line that is enabled, pending, not active and aimed at this CPU. The lowest priority value wins, and on a tie the lowest line number wins. It shows the winner's number and priority while the global enable bit is set. The CPU side acknowledges the shown line, which moves it from pending to active. Later the CPU side deactivates it by number.

Top module: `irq_distributor`

## Requirements
- R1: Bit 0 of the word at offset 0x000 is the global enable. It reads back as written, all other bits read 0, and while it is 0 `fwd_valid` stays low.
- R2: The word at offset 0x004 reads NUM_LINES/32-1 in bits [4:0] and 0 elsewhere. Writes to it change nothing.
- R3: Line i's enable is bit i%32 of word i/32 in two banks. A 1 written to the bank at 0x100 sets it and a 1 written to the bank at 0x180 clears it. Reading either bank returns the enable bits.
- R4: Pending uses the same mapping, with the set bank at 0x200 and the clear bank at 0x280. While line i's input is high its pending bit is forced to 1 every cycle, even against a clear. After the input falls the bit stays latched.
- R5: Active uses the same mapping, with the set bank at 0x300 and the clear bank at 0x380.
- R6: Line i's priority is byte i%4 (bits 8*(i%4)+7 down to 8*(i%4)) of word i/4 of the bank at 0x400. It reads back as written.
- R7: Line i's target byte sits at the same byte position in the bank at 0x800 and reads back. A line is a candidate only if bit CPU_IDX (default 0) of its target byte is 1, so a target of 0xFF always qualifies.
- R8: The shown line is the candidate (enabled, pending, not active, targeted) with the lowest priority value. On equal priority the lowest line number wins. `fwd_valid`, `fwd_id` and `fwd_prio` reflect the state registered at the previous clock edge.
- R9: A `cpu_ack` while `fwd_valid` is high sets the active bit of the shown line and clears its pending bit, unless the line's input is high. A `cpu_ack` while `fwd_valid` is low has no effect.
- R10: A `cpu_deact` clears the active bit of line `cpu_deact_id`.
- R11: Offsets that map to no implemented register read 0, and writes to them change no state. This covers words beyond the last line, 0x008–0x0FF and 0xC00–0xFFF.
- R12: After reset every state bit, priority, target and the global enable are 0, and `fwd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 12 | Byte address of the word, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | NUM_LINES | Level interrupt inputs |
| fwd_valid | output | 1 | A line is being offered to the CPU |
| fwd_id | output | ID_W | Number of the offered line |
| fwd_prio | output | 8 | Priority of the offered line |
| cpu_ack | input | 1 | Acknowledge the offered line |
| cpu_deact | input | 1 | Deactivate line `cpu_deact_id` |
| cpu_deact_id | input | ID_W | Line to deactivate |

## Verification
The assertion that an acknowledged line is not offered again on the next cycle has a precondition. It assumes that no bus write and no deactivation happen in the cycle of the acknowledge, since either could legally bring the line back. The gating and read-value properties assume that writes carry a full word. The random stimulus draws writes, acknowledges and deactivations one per operation, so these assumptions hold. It also holds the interrupt inputs low, so that pending changes come only from the register banks. Directed sequences then cover ties, target masking, ignored acknowledges and the level override separately.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int PRIO_W  = 8;
    // region = addr[11:10]
    localparam logic [1:0] RG_STATE = 2'd0;
    localparam logic [1:0] RG_PRIO  = 2'd1;
    localparam logic [1:0] RG_TGT   = 2'd2;
    // bank = addr[9:7] inside RG_STATE
    localparam logic [2:0] BK_MISC     = 3'd0;
    localparam logic [2:0] BK_SET_EN   = 3'd2;
    localparam logic [2:0] BK_CLR_EN   = 3'd3;
    localparam logic [2:0] BK_SET_PEND = 3'd4;
    localparam logic [2:0] BK_CLR_PEND = 3'd5;
    localparam logic [2:0] BK_SET_ACT  = 3'd6;
    localparam logic [2:0] BK_CLR_ACT  = 3'd7;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h000;
endpackage

// File: rtl/irq_dist_arb.sv
module irq_dist_arb
    import irq_dist_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ID_W      = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]        cand,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
    output logic                        hit,
    output logic [ID_W-1:0]             win_id,
    output logic [PRIO_W-1:0]           win_prio
);
    // Linear scan: strict "less than" keeps the lower index on ties.
    always_comb begin
        hit      = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand[i] && (!hit || prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
                hit      = 1'b1;
                win_id   = ID_W'(i);
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
    import irq_dist_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int CPU_IDX   = 0,
    parameter int ID_W      = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_LINES-1:0]        irq_lines,
    input  logic                        ack,
    input  logic [ID_W-1:0]             ack_id,
    input  logic                        deact,
    input  logic [ID_W-1:0]             deact_id,
    output logic [NUM_LINES-1:0]        cand,
    output logic [NUM_LINES*PRIO_W-1:0] prio_flat,
    output logic                        fwd_en
);
    localparam int WORDS  = NUM_LINES / 32;
    localparam int PWORDS = NUM_LINES / 4;

    typedef struct packed {
        logic                        gen;
        logic [NUM_LINES-1:0]        en;
        logic [NUM_LINES-1:0]        pend;
        logic [NUM_LINES-1:0]        act;
        logic [NUM_LINES*PRIO_W-1:0] prio;
        logic [NUM_LINES*PRIO_W-1:0] tgt;
    } state_t;

    state_t st_d, st_q;

    logic [1:0] region;
    logic [2:0] bank;
    logic [4:0] word;
    logic [7:0] pword;
    logic [NUM_LINES-1:0] wmask, m_se, m_ce, m_sp, m_cp, m_sa, m_ca;
    logic [NUM_LINES-1:0] ack_mask, deact_mask;

    assign region = bus_addr[11:10];
    assign bank   = bus_addr[9:7];
    assign word   = bus_addr[6:2];
    assign pword  = bus_addr[9:2];

    function automatic logic [DATA_W-1:0] pick(input logic [NUM_LINES-1:0] v,
                                               input logic [4:0] wd);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int w = 0; w < WORDS; w++)
            if (wd == 5'(w)) r = v[w*32 +: 32];
        return r;
    endfunction

    always_comb begin
        wmask = '0;
        for (int w = 0; w < WORDS; w++)
            if (word == 5'(w)) wmask[w*32 +: 32] = bus_wdata;
    end

    always_comb begin
        m_se = (bus_we && region == RG_STATE && bank == BK_SET_EN)   ? wmask : '0;
        m_ce = (bus_we && region == RG_STATE && bank == BK_CLR_EN)   ? wmask : '0;
        m_sp = (bus_we && region == RG_STATE && bank == BK_SET_PEND) ? wmask : '0;
        m_cp = (bus_we && region == RG_STATE && bank == BK_CLR_PEND) ? wmask : '0;
        m_sa = (bus_we && region == RG_STATE && bank == BK_SET_ACT)  ? wmask : '0;
        m_ca = (bus_we && region == RG_STATE && bank == BK_CLR_ACT)  ? wmask : '0;
        ack_mask   = ack   ? (NUM_LINES'(1) << ack_id)   : '0;
        deact_mask = deact ? (NUM_LINES'(1) << deact_id) : '0;

        st_d = st_q;
        if (bus_we && bus_addr == CTRL_ADDR) st_d.gen = bus_wdata[0];
        st_d.en   = (st_q.en | m_se) & ~m_ce;
        st_d.pend = ((st_q.pend | m_sp) & ~m_cp & ~ack_mask) | irq_lines;
        st_d.act  = ((st_q.act | m_sa | ack_mask) & ~m_ca) & ~deact_mask;
        for (int q = 0; q < PWORDS; q++) begin
            if (bus_we && region == RG_PRIO && pword == 8'(q))
                st_d.prio[q*32 +: 32] = bus_wdata;
            if (bus_we && region == RG_TGT && pword == 8'(q))
                st_d.tgt[q*32 +: 32] = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (region)
            RG_STATE: begin
                case (bank)
                    BK_MISC: begin
                        if (word == 5'd0)      bus_rdata = {31'b0, st_q.gen};
                        else if (word == 5'd1) bus_rdata = DATA_W'(WORDS - 1);
                    end
                    BK_SET_EN,   BK_CLR_EN:   bus_rdata = pick(st_q.en, word);
                    BK_SET_PEND, BK_CLR_PEND: bus_rdata = pick(st_q.pend, word);
                    BK_SET_ACT,  BK_CLR_ACT:  bus_rdata = pick(st_q.act, word);
                    default: ;
                endcase
            end
            RG_PRIO: begin
                for (int q = 0; q < PWORDS; q++)
                    if (pword == 8'(q)) bus_rdata = st_q.prio[q*32 +: 32];
            end
            RG_TGT: begin
                for (int q = 0; q < PWORDS; q++)
                    if (pword == 8'(q)) bus_rdata = st_q.tgt[q*32 +: 32];
            end
            default: ;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++)
            cand[i] = st_q.en[i] & st_q.pend[i] & ~st_q.act[i]
                    & st_q.tgt[i*PRIO_W + CPU_IDX];
    end

    assign prio_flat = st_q.prio;
    assign fwd_en    = st_q.gen;
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irq_dist_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int CPU_IDX   = 0,
    parameter int ID_W      = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic                 fwd_valid,
    output logic [ID_W-1:0]      fwd_id,
    output logic [7:0]           fwd_prio,
    input  logic                 cpu_ack,
    input  logic                 cpu_deact,
    input  logic [ID_W-1:0]      cpu_deact_id
);
    logic [NUM_LINES-1:0]        cand;
    logic [NUM_LINES*PRIO_W-1:0] prio_flat;
    logic                        fwd_en;
    logic                        hit;
    logic [ID_W-1:0]             win_id;
    logic [PRIO_W-1:0]           win_prio;

    irq_dist_regs #(.NUM_LINES(NUM_LINES), .CPU_IDX(CPU_IDX), .ID_W(ID_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lines (irq_in),
        .ack       (cpu_ack & fwd_valid),
        .ack_id    (win_id),
        .deact     (cpu_deact),
        .deact_id  (cpu_deact_id),
        .cand      (cand),
        .prio_flat (prio_flat),
        .fwd_en    (fwd_en)
    );

    irq_dist_arb #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_arb (
        .cand      (cand),
        .prio_flat (prio_flat),
        .hit       (hit),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    assign fwd_valid = hit & fwd_en;
    assign fwd_id    = win_id;
    assign fwd_prio  = win_prio;
endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk #(
    parameter int NUM_LINES = 64,
    parameter int ID_W      = $clog2(NUM_LINES)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_we,
    input logic [11:0]     bus_addr,
    input logic [31:0]     bus_wdata,
    input logic [31:0]     bus_rdata,
    input logic            fwd_valid,
    input logic [ID_W-1:0] fwd_id,
    input logic            cpu_ack,
    input logic            cpu_deact
);
    p_gen_off_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 12'h000 && !bus_wdata[0]) |=> !fwd_valid);

    p_type_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 12'h004) |-> (bus_rdata == 32'(NUM_LINES/32 - 1)));

    p_acked_not_reoffered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && cpu_ack && !bus_we && !cpu_deact)
        |=> !(fwd_valid && fwd_id == $past(fwd_id)));

    p_reserved_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[11:10] == 2'd3 || bus_addr[11:7] == 5'd1) |-> (bus_rdata == 32'd0));

    p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !fwd_valid);
endmodule

bind irq_distributor irq_distributor_chk #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .fwd_valid (fwd_valid),
    .fwd_id    (fwd_id),
    .cpu_ack   (cpu_ack),
    .cpu_deact (cpu_deact)
);

// File: tb/sim_irq_distributor.sv
module sim_irq_distributor;
    localparam int NL   = 64;
    localparam int IDW  = $clog2(NL);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_we = 1'b0;
    logic [11:0]    bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NL-1:0]  irq_in = '0;
    logic           fwd_valid;
    logic [IDW-1:0] fwd_id;
    logic [7:0]     fwd_prio;
    logic           cpu_ack = 1'b0;
    logic           cpu_deact = 1'b0;
    logic [IDW-1:0] cpu_deact_id = '0;

    int n_cmp = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    irq_distributor #(.NUM_LINES(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_prio(fwd_prio),
        .cpu_ack(cpu_ack), .cpu_deact(cpu_deact), .cpu_deact_id(cpu_deact_id)
    );

    // ---------------- reference model ----------------
    bit          m_gen;
    bit [NL-1:0] m_en, m_pend, m_act;
    bit [7:0]    m_prio [NL];
    bit [7:0]    m_tgt  [NL];

    function automatic void mwrite(input logic [11:0] a, input logic [31:0] d);
        int w;
        w = int'(a[6:2]);
        if (a == 12'h000) m_gen = d[0];
        else if (a[11:10] == 2'd0 && w < NL/32) begin
            for (int b = 0; b < 32; b++) if (d[b]) begin
                case (a[9:7])
                    3'd2: m_en[w*32+b]   = 1'b1;
                    3'd3: m_en[w*32+b]   = 1'b0;
                    3'd4: m_pend[w*32+b] = 1'b1;
                    3'd5: m_pend[w*32+b] = 1'b0;
                    3'd6: m_act[w*32+b]  = 1'b1;
                    3'd7: m_act[w*32+b]  = 1'b0;
                    default: ;
                endcase
            end
        end else if (a[11:10] == 2'd1 && int'(a[9:2]) < NL/4) begin
            for (int k = 0; k < 4; k++) m_prio[int'(a[9:2])*4+k] = d[8*k +: 8];
        end else if (a[11:10] == 2'd2 && int'(a[9:2]) < NL/4) begin
            for (int k = 0; k < 4; k++) m_tgt[int'(a[9:2])*4+k] = d[8*k +: 8];
        end
    endfunction

    function automatic logic [31:0] mread(input logic [11:0] a);
        logic [31:0] r;
        int w;
        r = '0;
        w = int'(a[6:2]);
        if (a == 12'h000) r = {31'b0, m_gen};
        else if (a == 12'h004) r = 32'(NL/32 - 1);
        else if (a[11:10] == 2'd0 && w < NL/32 && a[9:7] >= 3'd2) begin
            for (int b = 0; b < 32; b++)
                r[b] = (a[9:8] == 2'b01) ? m_en[w*32+b] :
                       (a[9:8] == 2'b10) ? m_pend[w*32+b] : m_act[w*32+b];
        end else if (a[11:10] == 2'd1 && int'(a[9:2]) < NL/4) begin
            for (int k = 0; k < 4; k++) r[8*k +: 8] = m_prio[int'(a[9:2])*4+k];
        end else if (a[11:10] == 2'd2 && int'(a[9:2]) < NL/4) begin
            for (int k = 0; k < 4; k++) r[8*k +: 8] = m_tgt[int'(a[9:2])*4+k];
        end
        return r;
    endfunction

    function automatic void mexp(output bit v, output int id, output bit [7:0] p);
        v = 0; id = 0; p = 8'hFF;
        for (int i = 0; i < NL; i++)
            if (m_en[i] && m_pend[i] && !m_act[i] && m_tgt[i][0] && (!v || m_prio[i] < p)) begin
                v = 1; id = i; p = m_prio[i];
            end
        v = v & m_gen;
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        mwrite(a, d);
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic chk_fwd(input string tag);
        bit v; int id; bit [7:0] p;
        mexp(v, id, p);
        chk({tag, " valid"}, 32'(fwd_valid), 32'(v));
        if (v && fwd_valid) begin
            chk({tag, " id"}, 32'(fwd_id), 32'(id));
            chk({tag, " prio"}, 32'(fwd_prio), 32'(p));
        end
    endtask

    task automatic do_ack();
        bit v; int id; bit [7:0] p;
        mexp(v, id, p);
        @(negedge clk);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        if (v) begin m_act[id] = 1'b1; m_pend[id] = irq_in[id]; end
    endtask

    task automatic do_deact(input int id);
        @(negedge clk);
        cpu_deact = 1'b1; cpu_deact_id = IDW'(id);
        @(negedge clk);
        cpu_deact = 1'b0;
        m_act[id] = 1'b0;
    endtask

    task automatic line_setup(input int id, input bit [7:0] pr);
        logic [31:0] pw;
        logic [31:0] tw;
        pw = mread(12'h400 + 12'(4*(id/4)));
        tw = mread(12'h800 + 12'(4*(id/4)));
        pw[8*(id%4) +: 8] = pr;
        tw[8*(id%4) +: 8] = 8'hFF;
        wr(12'h400 + 12'(4*(id/4)), pw);
        wr(12'h800 + 12'(4*(id/4)), tw);
        wr(12'h100 + 12'(4*(id/32)), 32'(1) << (id%32));
        wr(12'h200 + 12'(4*(id/32)), 32'(1) << (id%32));
    endtask

    task automatic wipe();
        wr(12'h180, '1); wr(12'h184, '1);
        wr(12'h280, '1); wr(12'h284, '1);
        wr(12'h380, '1); wr(12'h384, '1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        m_gen = 0; m_en = '0; m_pend = '0; m_act = '0;
        for (int i = 0; i < NL; i++) begin m_prio[i] = '0; m_tgt[i] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd("R12 ctrl", 12'h000, 32'd0);
        rd("R12 enable", 12'h100, 32'd0);
        rd("R12 target", 12'h800, 32'd0);
        chk("R12 fwd_valid", 32'(fwd_valid), 32'd0);

        // R2 type register, write ignored
        rd("R2 type", 12'h004, 32'(NL/32 - 1));
        wr(12'h004, 32'hFFFF_FFFF);
        rd("R2 type after write", 12'h004, 32'(NL/32 - 1));

        // R1/R8 single line, then global enable off
        wr(12'h000, 32'd1);
        rd("R1 ctrl readback", 12'h000, 32'd1);
        line_setup(5, 8'h40);
        chk_fwd("R8 single line");
        chk("R8 single id", 32'(fwd_id), 32'd5);
        wr(12'h000, 32'd0);
        chk("R1 gated", 32'(fwd_valid), 32'd0);
        wr(12'h000, 32'd1);

        // R8 tie and priority order
        line_setup(9, 8'h40);
        line_setup(3, 8'h40);
        chk("R8 tie lowest id", 32'(fwd_id), 32'd3);
        line_setup(40, 8'h10);
        chk("R8 lower value wins", 32'(fwd_id), 32'd40);
        chk("R8 prio", 32'(fwd_prio), 32'h10);

        // R7 target bit 0 clear removes line 40
        wr(12'h828, 32'hFFFF_FFFE & mread(12'h828));
        chk("R7 untargeted skipped", 32'(fwd_id), 32'd3);
        rd("R7 target readback", 12'h828, mread(12'h828));

        // R9 ack moves pending to active; R5 readback
        do_ack();
        chk("R9 ack moves on", 32'(fwd_id), 32'd5);
        rd("R5 active bit", 12'h300, 32'h8);
        rd("R4 pending cleared", 12'h200, 32'h0000_0220);
        // R9 ack ignored when nothing offered
        wr(12'h000, 32'd0);
        do_ack();
        rd("R9 ignored ack", 12'h300, 32'h8);
        wr(12'h000, 32'd1);
        // R10 deactivate
        do_deact(3);
        rd("R10 active cleared", 12'h380, 32'h0);
        chk_fwd("R10 after deact");

        // R4 level input overrides clear, then latches
        @(negedge clk);
        irq_in[50] = 1'b1;
        @(negedge clk);
        m_pend[50] = 1'b1;
        wr(12'h284, 32'(1) << 18);
        m_pend[50] = 1'b1;
        rd("R4 level holds", 12'h204, 32'(1) << 18 | mread(12'h204));
        irq_in[50] = 1'b0;
        @(negedge clk);
        rd("R4 latched", 12'h204, mread(12'h204));
        wr(12'h284, 32'(1) << 18);
        rd("R4 cleared", 12'h204, mread(12'h204));

        // R11 reserved writes
        wr(12'h0FC, '1);
        wr(12'hC00, '1);
        wr(12'h108, '1);
        rd("R11 reserved read", 12'hC00, 32'd0);
        rd("R11 unimplemented word", 12'h108, 32'd0);
        rd("R11 enable untouched", 12'h104, mread(12'h104));
        chk_fwd("R11 fwd untouched");

        // R6 priority readback
        wr(12'h404, 32'hC0_80_40_00);
        rd("R6 prio readback", 12'h404, 32'hC0_80_40_00);

        // constrained random phase
        wipe();
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 12);
            if (op <= 5) begin
                d = $urandom & $urandom;
                wr(12'h100 + 12'(128 * ($urandom % 6)) + 12'(4 * ($urandom % 3)), d);
            end else if (op == 6) begin
                for (int k = 0; k < 4; k++) d[8*k +: 8] = 8'(($urandom % 4) << 6);
                wr(12'h400 + 12'(4 * ($urandom % (NL/4))), d);
            end else if (op == 7) begin
                d = $urandom;
                wr(12'h800 + 12'(4 * ($urandom % (NL/4))), d);
            end else if (op == 8 || op == 9) begin
                do_ack();
            end else if (op == 10) begin
                do_deact(int'($urandom % NL));
            end else begin
                wr(12'h000, 32'(($urandom % 8) != 0));
            end
            chk_fwd("R8 random");
            begin
                logic [11:0] a;
                a = 12'h100 + 12'(128 * ($urandom % 6)) + 12'(4 * ($urandom % 2));
                if (($urandom % 3) == 0) a = 12'h400 + 12'(4 * ($urandom % (NL/4)));
                rd("R3 random readback", a, mread(a));
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule